// File: doc/BRIEF.md
# FIFO Read Sequencer

This block paces single reads from a FIFO. It idles until an enable input is high. It then waits a fixed number of clock cycles and pulses a one-cycle read request. After that it waits for the FIFO's data-valid acknowledge and pulses a completion flag. The design is built to avoid hangs. The controller takes only single-bit decisions. A separate saturating counter measures the delay and returns one terminal-count bit, and the controller drives back one clear bit. A second counter of the same kind acts as a watchdog over both wait states.

The state register is 3 bits wide and binary encoded: idle = 0, delay-wait = 1, request = 2, acknowledge-wait = 3, complete = 4. Codes 5, 6 and 7 are spare. Reset places the machine in code 5. On leaving reset, the machine steps through 5, 6 and 7 and then settles in idle. This keeps every spare code reachable in the built logic and gives each one a defined exit. Every output is taken straight from a flop. No output is decoded from the state.

Top module: `fifo_rd_sequencer`

## Requirements
- R1: While reset is low, rd_req_o, done_o, timeout_o and idle_o are all 0. After reset is released, idle_o stays low on the first and second rising edges and goes high on the third, as the machine steps through spare codes 5, 6 and 7.
- R2: In idle, a high ack_i is ignored: no output pulses and idle_o stays 1. The machine leaves idle only when start_i is high at a rising edge.
- R3: The delay counter is separate from the machine and is cleared while the machine is not in delay-wait. rd_req_o rises exactly DELAY_CYCLES+1 rising edges after the edge that samples start_i, and only after the counter reports terminal count.
- R4: rd_req_o is high for exactly one cycle per sequence.
- R5: If ack_i is sampled high during acknowledge-wait, done_o is high for exactly one cycle in the cycle that follows. On the next edge the machine is back in idle with idle_o at 1.
- R6: If ack_i is already high in the same cycle as the read request, it is not lost: done_o pulses in the next cycle.
- R7: If no acknowledge arrives, timeout_o pulses for one cycle WD_CYCLES+2 cycles after the cycle in which rd_req_o was high. In that same cycle idle_o returns to 1, and done_o does not pulse.
- R8: The watchdog bounds both wait states. The machine never stays in delay-wait or acknowledge-wait for more than WD_CYCLES+1 consecutive cycles.
- R9: Every state code outside the normal flow has a defined successor: 5 goes to 6, 6 goes to 7, and 7 goes to idle.
- R10: At most one of rd_req_o, done_o and timeout_o is high in any cycle, and rd_req_o and done_o are never high while idle_o is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Enable that starts a sequence from idle |
| ack_i | input | 1 | FIFO data-valid acknowledge |
| rd_req_o | output | 1 | One-cycle FIFO read request |
| done_o | output | 1 | One-cycle completion flag |
| timeout_o | output | 1 | One-cycle flag: acknowledge never arrived |
| idle_o | output | 1 | High while the machine rests in idle |

## Verification
The assertions check the following on every cycle: the spare-code successors, the hold in idle without an enable, single-cycle request and completion pulses, that a request only follows terminal count, that a timeout only follows watchdog expiry, the exclusivity of the outputs, and a running bound on time spent in a wait state. Only the bench scenarios can show the exact cycle counts. These are the delay from enable to request, the gap from acknowledge to completion (with the acknowledge both early and late), the timeout position, the release-from-reset sweep timing, and that an acknowledge in idle or after a timeout has no effect.

// File: rtl/fifo_rd_seq_pkg.sv
package fifo_rd_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_WAIT_CNT = 3'd1,
        ST_READ     = 3'd2,
        ST_WAIT_ACK = 3'd3,
        ST_DONE     = 3'd4,
        ST_SPARE_A  = 3'd5,
        ST_SPARE_B  = 3'd6,
        ST_SPARE_C  = 3'd7
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
        logic       rd_req;
        logic       done;
        logic       timeout;
        logic       cnt_clr;
        logic       wd_clr;
        logic       idle;
    } seq_regs_t;

endpackage

// File: rtl/rdseq_sat_timer.sv
module rdseq_sat_timer #(
    parameter int LIMIT = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    output logic hit_o
);
    localparam int W = $clog2(LIMIT + 1);
    localparam logic [W-1:0] LIM = W'(LIMIT);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (clr_i)
            cnt_d = '0;
        else if (cnt_q != LIM)
            cnt_d = cnt_q + 1'b1;
        else
            cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign hit_o = (cnt_q == LIM);

endmodule

// File: rtl/rdseq_fsm.sv
module rdseq_fsm
    import fifo_rd_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       ack_i,
    input  logic       tc_i,
    input  logic       wd_hit_i,
    output logic       rd_req_o,
    output logic       done_o,
    output logic       timeout_o,
    output logic       idle_o,
    output logic       cnt_clr_o,
    output logic       wd_clr_o,
    output logic [2:0] state_o
);
    seq_regs_t regs_d, regs_q;
    seq_state_e nxt;
    logic       to_ev;

    always_comb begin
        nxt   = regs_q.state;
        to_ev = 1'b0;
        case (regs_q.state)
            ST_SPARE_A:  nxt = ST_SPARE_B;
            ST_SPARE_B:  nxt = ST_SPARE_C;
            ST_SPARE_C:  nxt = ST_IDLE;
            ST_IDLE:     if (start_i) nxt = ST_WAIT_CNT;
            ST_WAIT_CNT: begin
                if (tc_i) begin
                    nxt = ST_READ;
                end else if (wd_hit_i) begin
                    nxt   = ST_IDLE;
                    to_ev = 1'b1;
                end
            end
            ST_READ:     nxt = ack_i ? ST_DONE : ST_WAIT_ACK;
            ST_WAIT_ACK: begin
                if (ack_i) begin
                    nxt = ST_DONE;
                end else if (wd_hit_i) begin
                    nxt   = ST_IDLE;
                    to_ev = 1'b1;
                end
            end
            ST_DONE:     nxt = ST_IDLE;
            default:     nxt = ST_IDLE;
        endcase

        regs_d.state   = nxt;
        regs_d.rd_req  = (nxt == ST_READ);
        regs_d.done    = (nxt == ST_DONE);
        regs_d.timeout = to_ev;
        regs_d.cnt_clr = (nxt != ST_WAIT_CNT);
        regs_d.wd_clr  = !((nxt == ST_WAIT_CNT) || (nxt == ST_WAIT_ACK));
        regs_d.idle    = (nxt == ST_IDLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '{state: ST_SPARE_A, rd_req: 1'b0, done: 1'b0,
                        timeout: 1'b0, cnt_clr: 1'b1, wd_clr: 1'b1,
                        idle: 1'b0};
        end else begin
            regs_q <= regs_d;
        end
    end

    assign rd_req_o  = regs_q.rd_req;
    assign done_o    = regs_q.done;
    assign timeout_o = regs_q.timeout;
    assign idle_o    = regs_q.idle;
    assign cnt_clr_o = regs_q.cnt_clr;
    assign wd_clr_o  = regs_q.wd_clr;
    assign state_o   = regs_q.state;

endmodule

// File: rtl/fifo_rd_sequencer.sv
module fifo_rd_sequencer #(
    parameter int DELAY_CYCLES = 128,
    parameter int WD_CYCLES    = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic ack_i,
    output logic rd_req_o,
    output logic done_o,
    output logic timeout_o,
    output logic idle_o
);
    logic       dly_clr, dly_tc;
    logic       wd_clr, wd_hit;
    logic [2:0] fsm_state;

    rdseq_sat_timer #(.LIMIT(DELAY_CYCLES)) u_delay (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (dly_clr),
        .hit_o (dly_tc)
    );

    rdseq_sat_timer #(.LIMIT(WD_CYCLES)) u_watchdog (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (wd_clr),
        .hit_o (wd_hit)
    );

    rdseq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .ack_i     (ack_i),
        .tc_i      (dly_tc),
        .wd_hit_i  (wd_hit),
        .rd_req_o  (rd_req_o),
        .done_o    (done_o),
        .timeout_o (timeout_o),
        .idle_o    (idle_o),
        .cnt_clr_o (dly_clr),
        .wd_clr_o  (wd_clr),
        .state_o   (fsm_state)
    );

endmodule

// File: rtl/fifo_rd_sequencer_chk.sv
module fifo_rd_sequencer_chk #(
    parameter int WD_CYCLES = 1024
) (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic       ack_i,
    input logic       rd_req_o,
    input logic       done_o,
    input logic       timeout_o,
    input logic       idle_o,
    input logic [2:0] state,
    input logic       tc,
    input logic       wd_hit
);
    int wait_run;
    logic in_wait;
    assign in_wait = (state == 3'd1) || (state == 3'd3);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       wait_run <= 0;
        else if (in_wait) wait_run <= wait_run + 1;
        else              wait_run <= 0;
    end

    assert_sweep_a_R9: assert property (@(posedge clk) disable iff (!rst_n)
        state == 3'd5 |=> state == 3'd6);
    assert_sweep_b_R9: assert property (@(posedge clk) disable iff (!rst_n)
        state == 3'd6 |=> state == 3'd7);
    assert_sweep_c_R1: assert property (@(posedge clk) disable iff (!rst_n)
        state == 3'd7 |=> (state == 3'd0 && idle_o));
    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 3'd0 && !start_i) |=> (state == 3'd0 && idle_o));
    assert_req_after_tc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |-> $past(tc));
    assert_req_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |=> !rd_req_o);
    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && idle_o));
    assert_timeout_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |-> ($past(wd_hit) && idle_o));
    assert_wait_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wait_run <= WD_CYCLES + 1);
    assert_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_req_o, done_o, timeout_o}) && !(idle_o && (rd_req_o || done_o)));

endmodule

bind fifo_rd_sequencer fifo_rd_sequencer_chk #(.WD_CYCLES(WD_CYCLES)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .ack_i     (ack_i),
    .rd_req_o  (rd_req_o),
    .done_o    (done_o),
    .timeout_o (timeout_o),
    .idle_o    (idle_o),
    .state     (fsm_state),
    .tc        (dly_tc),
    .wd_hit    (wd_hit)
);

// File: tb/test_fifo_rd_sequencer.sv
module test_fifo_rd_sequencer;
    localparam int CLK_PERIOD = 10;
    localparam int DLY = 128;
    localparam int WD  = 1024;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic ack_i = 1'b0;
    logic rd_req_o, done_o, timeout_o, idle_o;

    int cyc = 0;
    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    typedef struct { int kind; int at; } ev_t;   // kind: 1 request, 2 done, 3 timeout
    ev_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    fifo_rd_sequencer #(.DELAY_CYCLES(DLY), .WD_CYCLES(WD)) i_fifo_rd_sequencer (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .ack_i(ack_i),
        .rd_req_o(rd_req_o), .done_o(done_o), .timeout_o(timeout_o), .idle_o(idle_o)
    );

    function automatic string req_of(int k);
        return (k == 1) ? "R3" : (k == 2) ? "R5" : "R7";
    endfunction

    task automatic check(bit ok, string req, int act, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, expv);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (exp_q.size() > 0 && exp_q[0].at < cyc) begin
                check(1'b0, req_of(exp_q[0].kind), -1, exp_q[0].at);
                void'(exp_q.pop_front());
            end
            for (int k = 1; k <= 3; k++) begin
                logic bitv;
                bitv = (k == 1) ? rd_req_o : (k == 2) ? done_o : timeout_o;
                if (bitv) begin
                    if (exp_q.size() > 0 && exp_q[0].kind == k && exp_q[0].at == cyc) begin
                        check(1'b1, req_of(k), cyc, cyc);
                        void'(exp_q.pop_front());
                    end else begin
                        // unexpected pulse: R2 (ignored ack), R4 (single request), R5/R7 pulse width
                        check(1'b0, (k == 1) ? "R4" : (k == 2) ? "R2/R5" : "R7", cyc, -1);
                    end
                end
            end
        end
    end

    // ack_gap < 0: no acknowledge (timeout path)
    task automatic run_seq(int ack_gap);
        int n, c_r;
        n = cyc;
        start_i = 1'b1;
        c_r = n + DLY + 2;
        exp_q.push_back('{kind: 1, at: c_r});      // R3 timing
        @(negedge clk) start_i = 1'b0;
        while (cyc < c_r) @(negedge clk);
        if (ack_gap >= 0) begin
            repeat (ack_gap) @(negedge clk);
            exp_q.push_back('{kind: 2, at: cyc + 1}); // R5 / R6
            ack_i = 1'b1;
            @(negedge clk) ack_i = 1'b0;
            @(negedge clk);
            check(idle_o == 1'b1, "R5", idle_o, 1);
        end else begin
            exp_q.push_back('{kind: 3, at: c_r + WD + 2}); // R7
            while (cyc < c_r + WD + 2) @(negedge clk);
            check(idle_o == 1'b1, "R7", idle_o, 1);
        end
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check({rd_req_o, done_o, timeout_o, idle_o} == 4'b0, "R1",
              {rd_req_o, done_o, timeout_o, idle_o}, 0);
        rst_n = 1'b1;
        @(negedge clk) check(idle_o == 1'b0, "R1", idle_o, 0);
        @(negedge clk) check(idle_o == 1'b0, "R1", idle_o, 0);
        @(negedge clk) check(idle_o == 1'b1, "R1", idle_o, 1);
        repeat (2) @(negedge clk);

        // R2: ack while idle has no effect
        ack_i = 1'b1;
        repeat (5) begin
            @(negedge clk) check(idle_o == 1'b1, "R2", idle_o, 1);
        end
        ack_i = 1'b0;
        repeat (2) @(negedge clk);

        run_seq(3);   // R3 R4 R5
        run_seq(0);   // R6 ack in request cycle
        run_seq(1);   // R5 earliest ack in acknowledge-wait
        run_seq(-1);  // R7 timeout

        // R2: late ack after timeout is ignored
        ack_i = 1'b1;
        repeat (3) begin
            @(negedge clk) check(idle_o == 1'b1, "R2", idle_o, 1);
        end
        ack_i = 1'b0;
        run_seq(7);   // recovery after timeout, R5

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R3", exp_q.size(), 0);
        finished = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish, actual %0d expected %0d", cyc, 0);
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule